// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block sits between the load/store port of a 32-bit processor and a slower backing memory. It holds 1024 lines of one 32-bit word each (4 KB). It caches only accesses that fall inside two adjacent 1 MB address windows. Every other access goes straight to memory and never touches the line store. Reads of a byte, a halfword or a word hit in a single cycle when the line is present. A read miss fetches one aligned word from memory, fills the line and serves the read from the fetched word.

Writes are never held back. Each write, cacheable or not, is sent to memory with its address, size and data. A full-word write that is cacheable also refreshes the line with the new value and tag. A cacheable byte or halfword write does not merge into the line; it invalidates it instead.

Sub-word reads use big-endian lane order and return zero-extended data in the low bits, so sign extension is left to the processor. The processor raises a request and holds it steady until the block answers with a one-cycle ready pulse. Addresses are naturally aligned: halfword addresses are even and word addresses are multiples of four. The memory side holds its request until the memory answers with a done strobe, and it always returns the whole aligned word.

Top module: `wt_word_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any cacheable address is a miss and issues one memory read.
- R2: An access is cacheable only when address bits [31:20] are 0x100 or 0x101. Any other read goes to memory every time and never fills a line.
- R3: The line index is address bits [11:2] and the tag is bits [20:12]. A read hits only when the line is valid and the tags match. A hit issues no memory request and raises cpu_ready in the cycle after the request is accepted.
- R4: A cacheable read miss issues exactly one memory read at the word-aligned address with size word (2). It fills the line, so repeating the read hits.
- R5: Every write, in or out of the windows, issues exactly one memory write carrying the processor's address, size and data unchanged.
- R6: A cacheable word write stores the written value and tag in the line, so a following read of that address hits and returns the value.
- R7: A cacheable byte or halfword write invalidates the line, so the next read of that word misses and returns the merged word from memory.
- R8: A byte read (size 0) returns bits [8*(3-addr[1:0]) +: 8] of the word in data[7:0], with the upper bits zero.
- R9: A halfword read (size 1) returns bits [31:16] when addr[1] is 0 and bits [15:0] when addr[1] is 1, in data[15:0] with the upper bits zero.
- R10: cpu_ready is a single-cycle pulse for each accepted request. mem_req stays high, with its address, size and direction stable, until mem_done. cpu_ready is never high while mem_req is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data, right-aligned for sub-word writes |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, zero-extended, valid with cpu_ready |
| mem_req | output | 1 | Memory request, held until mem_done |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address (word-aligned for reads) |
| mem_size | output | 2 | Memory access size, same encoding as cpu_size |
| mem_wdata | output | 32 | Memory write data |
| mem_done | input | 1 | Memory completion strobe |
| mem_rdata | input | 32 | Aligned memory word, valid with mem_done |

## Verification
The bench targets addresses that share an index but differ in tag, including the window bit 20. A design that compared too few tag bits would return the other window's word from a stale hit. It probes the first and last words of both windows and their immediate neighbours outside. A loose window decode would either fill lines from peripheral space or send cacheable reads to memory on every access. After a word write it looks for a hit carrying the new value, and after a sub-word write it looks for a miss. A design that merged partial writes into the line, or left it valid, would show up as a wrong hit count or stale lanes. Every byte and halfword lane is read back against a memory model, which catches lane orders that are swapped or flipped to little-endian.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } access_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_RESP = 2'd2
   } ctl_state_e;
endpackage

// File: rtl/wtc_window_decode.sv
module wtc_window_decode #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned WIN_LSB = 21,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h080
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   localparam int unsigned CMP_W = ADDR_W - WIN_LSB;

   // Compare only the bits above the window span; bits below WIN_LSB vary freely.
   assign hit_o = (addr_i[ADDR_W-1:WIN_LSB] == WIN_BASE[CMP_W-1:0]);
endmodule

// File: rtl/wtc_lane_sel.sv
module wtc_lane_sel #(
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [31:0] word_i,
   input  logic [1:0]  lo_i,
   input  logic [1:0]  size_i,
   output logic [31:0] data_o
);
   import wtc_pkg::*;

   logic [1:0]  lane;
   logic [31:0] byte_sh;
   logic [31:0] half_sh;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign lane = lo_i ^ 2'b11;
      end else begin : g_little
         assign lane = lo_i;
      end
   endgenerate

   assign byte_sh = word_i >> {lane, 3'b000};
   assign half_sh = word_i >> {lane[1], 4'b0000};

   always_comb begin
      case (size_i)
         SZ_BYTE: data_o = {24'h0, byte_sh[7:0]};
         SZ_HALF: data_o = {16'h0, half_sh[15:0]};
         default: data_o = word_i;
      endcase
   end
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
   parameter int unsigned LINES  = 1024,
   parameter int unsigned TAG_W  = 9,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic              inv_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_mem  [LINES];
   logic [DATA_W-1:0] data_mem [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end else if (inv_en) begin
         valid_q[wr_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx]  <= wr_tag;
         data_mem[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_mem[rd_idx];
   assign rd_data  = data_mem[rd_idx];
endmodule

// File: rtl/wt_word_cache.sv
module wt_word_cache #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LINES    = 1024,
   parameter int unsigned WIN_LSB  = 21,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h080,
   parameter bit          BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_done,
   input  logic [DATA_W-1:0] mem_rdata
);
   import wtc_pkg::*;

   localparam int unsigned OFF_W   = $clog2(DATA_W / 8);
   localparam int unsigned IDX_W   = $clog2(LINES);
   localparam int unsigned TAG_LSB = OFF_W + IDX_W;
   localparam int unsigned TAG_W   = WIN_LSB - TAG_LSB;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("wt_word_cache: DATA_W must be 32");
      end
      if ((1 << IDX_W) != LINES) begin : g_bad_lines
         $error("wt_word_cache: LINES must be a power of two");
      end
      if (WIN_LSB <= TAG_LSB || WIN_LSB >= ADDR_W) begin : g_bad_window
         $error("wt_word_cache: window must lie above the index bits");
      end
   endgenerate

   ctl_state_e        state_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic              req_we_q;
   logic [1:0]        req_size_q;
   logic [DATA_W-1:0] req_wdata_q;
   logic              req_cach_q;
   logic [DATA_W-1:0] rdata_q;

   logic              cach_now;
   logic [IDX_W-1:0]  idx_now;
   logic [TAG_W-1:0]  tag_now;
   logic              line_valid;
   logic [TAG_W-1:0]  line_tag;
   logic [DATA_W-1:0] line_data;
   logic              hit_now;

   logic              fill_en;
   logic              inv_en;
   logic [DATA_W-1:0] fill_data;
   logic              in_idle;
   logic [DATA_W-1:0] lane_word;
   logic [1:0]        lane_lo;
   logic [1:0]        lane_size;
   logic [DATA_W-1:0] lane_out;

   wtc_window_decode #(
      .ADDR_W  (ADDR_W),
      .WIN_LSB (WIN_LSB),
      .WIN_BASE(WIN_BASE)
   ) u_win (
      .addr_i(cpu_addr),
      .hit_o (cach_now)
   );

   assign idx_now = cpu_addr[TAG_LSB-1:OFF_W];
   assign tag_now = cpu_addr[WIN_LSB-1:TAG_LSB];

   wtc_line_store #(
      .LINES (LINES),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (idx_now),
      .rd_valid(line_valid),
      .rd_tag  (line_tag),
      .rd_data (line_data),
      .wr_en   (fill_en),
      .inv_en  (inv_en),
      .wr_idx  (req_addr_q[TAG_LSB-1:OFF_W]),
      .wr_tag  (req_addr_q[WIN_LSB-1:TAG_LSB]),
      .wr_data (fill_data)
   );

   assign hit_now = cach_now && line_valid && (line_tag == tag_now);

   // Line updates happen when the memory side completes.
   assign fill_en   = (state_q == ST_MEM) && mem_done && req_cach_q &&
                      (!req_we_q || (req_size_q == SZ_WORD));
   assign inv_en    = (state_q == ST_MEM) && mem_done && req_cach_q &&
                      req_we_q && (req_size_q != SZ_WORD);
   assign fill_data = req_we_q ? req_wdata_q : mem_rdata;

   // One lane extractor serves both the hit path and the miss return path.
   assign in_idle   = (state_q == ST_IDLE);
   assign lane_word = in_idle ? line_data : mem_rdata;
   assign lane_lo   = in_idle ? cpu_addr[1:0] : req_addr_q[1:0];
   assign lane_size = in_idle ? cpu_size : req_size_q;

   wtc_lane_sel #(.BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .word_i(lane_word),
      .lo_i  (lane_lo),
      .size_i(lane_size),
      .data_o(lane_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         req_addr_q  <= '0;
         req_we_q    <= 1'b0;
         req_size_q  <= 2'd0;
         req_wdata_q <= '0;
         req_cach_q  <= 1'b0;
         rdata_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  req_addr_q  <= cpu_addr;
                  req_we_q    <= cpu_we;
                  req_size_q  <= cpu_size;
                  req_wdata_q <= cpu_wdata;
                  req_cach_q  <= cach_now;
                  if (!cpu_we && hit_now) begin
                     rdata_q <= lane_out;
                     state_q <= ST_RESP;
                  end else begin
                     state_q <= ST_MEM;
                  end
               end
            end
            ST_MEM: begin
               if (mem_done) begin
                  if (!req_we_q) begin
                     rdata_q <= lane_out;
                  end
                  state_q <= ST_RESP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready = (state_q == ST_RESP);
   assign cpu_rdata = rdata_q;
   assign mem_req   = (state_q == ST_MEM);
   assign mem_we    = req_we_q;
   assign mem_addr  = req_we_q ? req_addr_q : {req_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mem_size  = req_we_q ? req_size_q : SZ_WORD;
   assign mem_wdata = req_wdata_q;
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic [1:0]        cpu_size,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_size,
   input logic              mem_done
);
   assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) &&
                                  $stable(mem_we) && $stable(mem_size)));

   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);

   assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_done) |=> !mem_req);

   assert_fill_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00 && mem_size == 2'd2));

   assert_write_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr == cpu_addr && mem_size == cpu_size));

   assert_ready_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |=> !cpu_ready);
endmodule

bind wt_word_cache wtc_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_size (cpu_size),
   .cpu_addr (cpu_addr),
   .cpu_ready(cpu_ready),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_size (mem_size),
   .mem_done (mem_done)
);

// File: tb/wt_word_cache_test.sv
`timescale 1ns/1ps
module wt_word_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [1:0]  cpu_size = 2'd0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic [31:0] mem_wdata;
   logic        mem_done = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   wt_word_cache uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_done(mem_done), .mem_rdata(mem_rdata)
   );

   // ---------------- reference memory and responder ----------------
   logic [31:0] mem [8192];
   bit          ref_vld [1024];
   logic [8:0]  ref_tag [1024];
   bit          busy = 0;
   int          wait_cnt = 0;
   int          txn_count = 0;
   logic        last_we;
   logic [31:0] last_addr;
   logic [1:0]  last_size;
   logic [31:0] last_wdata;

   function automatic bit cacheable(input logic [31:0] a);
      return (a[31:20] == 12'h100) || (a[31:20] == 12'h101);
   endfunction

   function automatic int midx(input logic [31:0] a);
      return {19'd0, cacheable(a), a[13:2]};
   endfunction

   function automatic logic [31:0] lane_ref(input logic [31:0] w, input logic [1:0] lo,
                                            input logic [1:0] sz);
      logic [31:0] r;
      case (sz)
         2'd0: r = {24'h0, w[8*(3-lo) +: 8]};
         2'd1: r = lo[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
         default: r = w;
      endcase
      return r;
   endfunction

   task automatic apply_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
      int i = midx(a);
      case (sz)
         2'd0: mem[i][8*(3-a[1:0]) +: 8] = d[7:0];
         2'd1: if (a[1]) mem[i][15:0] = d[15:0]; else mem[i][31:16] = d[15:0];
         default: mem[i] = d;
      endcase
   endtask

   always @(negedge clk) begin
      if (mem_done) begin
         mem_done = 1'b0;
         busy = 0;
      end else if (busy) begin
         if (wait_cnt == 0) begin
            if (last_we) apply_write(last_addr, last_size, last_wdata);
            else mem_rdata = mem[midx(last_addr)];
            mem_done = 1'b1;
         end else begin
            wait_cnt = wait_cnt - 1;
         end
      end else if (mem_req) begin
         busy = 1;
         wait_cnt = int'($urandom_range(0, 2));
         txn_count = txn_count + 1;
         last_we = mem_we;
         last_addr = mem_addr;
         last_size = mem_size;
         last_wdata = mem_wdata;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   int last_hits;

   task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] d, output logic [31:0] rd);
      int cycles = 0;
      int t0 = txn_count;
      bit cach = cacheable(a);
      int idx = int'(a[11:2]);
      bit exp_hit = !we && cach && ref_vld[idx] && ref_tag[idx] == a[20:12];
      logic [31:0] exp_rd;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
      do begin
         @(negedge clk);
         cycles++;
      end while (!cpu_ready && cycles < 50);
      rd = cpu_rdata;
      cpu_req = 1'b0;
      last_hits = exp_hit ? 1 : 0;
      check(cpu_ready == 1'b1, "R10 ready", {31'd0, cpu_ready}, 32'd1);
      if (exp_hit) begin
         check(txn_count == t0 && cycles == 1, "R3 hit without memory",
               txn_count - t0, 0);
      end else begin
         check(txn_count == t0 + 1, cach ? "R4 one memory access" : "R2 bypass access",
               txn_count - t0, 1);
      end
      if (we) begin
         check(last_we && last_addr == a && last_size == sz && last_wdata == d,
               "R5 write fields", last_addr, a);
         if (cach) begin
            ref_vld[idx] = (sz == 2'd2);
            ref_tag[idx] = a[20:12];
         end
      end else begin
         exp_rd = lane_ref(mem[midx(a)], a[1:0], sz);
         check(rd == exp_rd, sz == 2'd0 ? "R8 byte data" : (sz == 2'd1 ? "R9 half data" : "R4 word data"),
               rd, exp_rd);
         if (!exp_hit)
            check(last_addr == {a[31:2], 2'b00} && last_size == 2'd2 && !last_we,
                  "R4 aligned fill", last_addr, {a[31:2], 2'b00});
         if (cach) begin
            ref_vld[idx] = 1;
            ref_tag[idx] = a[20:12];
         end
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] rd;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8192; i++) mem[i] = $urandom;
      for (int i = 0; i < 1024; i++) begin ref_vld[i] = 0; ref_tag[i] = '0; end
      repeat (3) @(negedge clk);
      check(cpu_ready == 0 && mem_req == 0, "R10 reset outputs", {30'd0, cpu_ready, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: first read after reset misses
      access(0, 2'd2, 32'h1000_0000, 0, rd);
      check(last_hits == 0, "R1 cold miss", last_hits, 0);
      access(0, 2'd2, 32'h1000_0000, 0, rd);
      check(last_hits == 1, "R4 refill then hit", last_hits, 1);
      // R8 / R9 all lanes on a resident line
      for (int b = 0; b < 4; b++) access(0, 2'd0, 32'h1000_0000 + b, 0, rd);
      access(0, 2'd1, 32'h1000_0000, 0, rd);
      access(0, 2'd1, 32'h1000_0002, 0, rd);
      // R6 word write then hit
      access(1, 2'd2, 32'h1000_0004, 32'hCAFE_F00D, rd);
      access(0, 2'd2, 32'h1000_0004, 0, rd);
      check(last_hits == 1 && rd == 32'hCAFE_F00D, "R6 write update", rd, 32'hCAFE_F00D);
      // R7 byte and half writes invalidate
      access(1, 2'd0, 32'h1000_0005, 32'h0000_00A5, rd);
      access(0, 2'd2, 32'h1000_0004, 0, rd);
      check(last_hits == 0 && rd == 32'hCAA5_F00D, "R7 byte invalidate", rd, 32'hCAA5_F00D);
      access(1, 2'd1, 32'h1000_0006, 32'h0000_1234, rd);
      access(0, 2'd2, 32'h1000_0004, 0, rd);
      check(last_hits == 0 && rd == 32'hCAA5_1234, "R7 half invalidate", rd, 32'hCAA5_1234);
      // R3 tag conflicts on the same index, including window bit 20
      access(0, 2'd2, 32'h1000_1000, 0, rd);
      check(last_hits == 0, "R3 tag conflict miss", last_hits, 0);
      access(0, 2'd2, 32'h1010_0000, 0, rd);
      check(last_hits == 0, "R3 window bit miss", last_hits, 0);
      access(0, 2'd2, 32'h1000_0000, 0, rd);
      check(last_hits == 0, "R3 evicted line miss", last_hits, 0);
      // R2 window edges and bypass
      access(0, 2'd2, 32'h101F_FFFC, 0, rd);
      access(0, 2'd2, 32'h101F_FFFC, 0, rd);
      check(last_hits == 1, "R2 last window word cached", last_hits, 1);
      access(0, 2'd2, 32'h1020_0000, 0, rd);
      access(0, 2'd2, 32'h1020_0000, 0, rd);
      check(last_hits == 0, "R2 above window bypass", last_hits, 0);
      access(0, 2'd2, 32'h0FFF_FFFC, 0, rd);
      access(0, 2'd2, 32'h0FFF_FFFC, 0, rd);
      check(last_hits == 0, "R2 below window bypass", last_hits, 0);
      access(1, 2'd2, 32'h2000_0010, 32'h5555_AAAA, rd);
      access(0, 2'd2, 32'h2000_0010, 0, rd);
      check(rd == 32'h5555_AAAA, "R5 bypass write reached memory", rd, 32'h5555_AAAA);

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] base, a, d;
         logic [1:0] sz;
         logic we;
         case ($urandom_range(0, 4))
            0, 1: base = 32'h1000_0000;
            2:    base = 32'h1010_0000;
            3:    base = 32'h2000_0000;
            default: base = 32'h0FF0_0000;
         endcase
         a = base + ($urandom_range(0, 32'h2FFF) & 32'h0000_3FFF);
         sz = 2'($urandom_range(0, 2));
         if (sz == 2'd1) a[0] = 1'b0;
         if (sz == 2'd2) a[1:0] = 2'b00;
         we = ($urandom_range(0, 9) < 3);
         d = $urandom;
         if (sz == 2'd0) d = {24'h0, d[7:0]};
         if (sz == 2'd1) d = {16'h0, d[15:0]};
         access(we, sz, a, d, rd);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=0x%08h expected=0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule